// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the combinational arithmetic and logic stage of a simple 32-bit load/store processor. It receives two register operands, a 16-bit immediate, a 4-bit operation code, a flag that chooses the immediate in place of the second operand, and the index of the destination register. In the same cycle it returns the result word, a write-enable for the register file and a trap flag for signed overflow.

The supported operations are add, subtract, the wrapping (unsigned) add and subtract, AND, OR, XOR, NOR, signed and unsigned set-less-than, and load-upper-immediate. The block has no states; each output is a pure function of the present inputs. The trap flag is only a flag. Exception handling belongs to the surrounding pipeline, and so do the register file and instruction decode.

Top module: `alu_exec`

## Requirements
- R1: For op 0 (ADD) and op 2 (SUB), in both the register form and the immediate form, a signed result outside [-2^31, 2^31-1] sets ovf_trap=1 and wr_en=0. Otherwise ovf_trap=0 and result holds the sum or the difference.
- R2: Op 1 (ADDU) and op 3 (SUBU) return the sum or difference modulo 2^32 and never set ovf_trap.
- R3: When use_imm=1, ops 0, 1, 2, 3 and 8 use imm sign-extended to 32 bits as the second operand. When use_imm=0, opnd_b is used and imm has no effect.
- R4: Op 9 (SLTU) with use_imm=1 sign-extends imm to 32 bits and then compares the two operands as unsigned numbers.
- R5: When use_imm=1, ops 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) use imm zero-extended to 32 bits.
- R6: Op 10 (LUI) returns imm in bits 31:16 with bits 15:0 cleared. It ignores opnd_a, opnd_b and use_imm.
- R7: Op 7 (NOR) returns ~(A | B).
- R8: Op 8 (SLT, signed compare) and op 9 (SLTU, unsigned compare) return 1 when A < B and 0 otherwise.
- R9: When dest_idx is 0, wr_en is 0 for every op. ovf_trap is still reported.
- R10: Op codes 11 to 15 are not assigned. For these codes result=0, wr_en=0 and ovf_trap=0.
- R11: Ops 4, 5 and 6 return A & B, A | B and A ^ B respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand (register form) |
| imm | input | 16 | Immediate field |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | Use the extended immediate as the second operand |
| dest_idx | input | 5 | Destination register index |
| result | output | 32 | Result word |
| wr_en | output | 1 | Register file write-enable |
| ovf_trap | output | 1 | Signed-overflow trap flag |

## Verification
The assertions take for granted that every input carries a known 0 or 1 value. They also assume the inputs have settled before anything is sampled, because the checks evaluate combinational outputs. The stimulus drives every input on each step, including imm during register-form steps, so no input is ever left undriven. It samples half a clock period after driving. The operand values sit at the sign and carry boundaries, so the overflow and wrap cases come up under every op code.

// File: rtl/alu_exec_pkg.sv
`timescale 1ns/1ps
package alu_exec_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_LUI  = 4'd10
    } alu_op_e;

    function automatic logic op_zero_ext(input alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    endfunction

    function automatic logic op_traps(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/imm_extend.sv
`timescale 1ns/1ps
module imm_extend #(
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm_in,
    input  logic              zero_ext,
    output logic [DATA_W-1:0] ext_out
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic pad_bit;

    always_comb begin
        pad_bit = zero_ext ? 1'b0 : imm_in[IMM_W-1];
        ext_out = {{PAD_W{pad_bit}}, imm_in};
    end
endmodule

// File: rtl/addsub_unit.sv
`timescale 1ns/1ps
module addsub_unit #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum_out,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    always_comb begin
        b_eff   = do_sub ? ~in_b : in_b;
        wide    = {1'b0, in_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
        sum_out = wide[DATA_W-1:0];
        ovf     = (in_a[MSB] == b_eff[MSB]) && (sum_out[MSB] != in_a[MSB]);
    end
endmodule

// File: rtl/logic_cmp_unit.sv
`timescale 1ns/1ps
module logic_cmp_unit
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] out_val
);
    always_comb begin
        unique case (op)
            OP_AND:  out_val = in_a & in_b;
            OP_OR:   out_val = in_a | in_b;
            OP_XOR:  out_val = in_a ^ in_b;
            OP_NOR:  out_val = ~(in_a | in_b);
            OP_SLT:  out_val = {{(DATA_W-1){1'b0}}, ($signed(in_a) < $signed(in_b))};
            OP_SLTU: out_val = {{(DATA_W-1){1'b0}}, (in_a < in_b)};
            default: out_val = '0;
        endcase
    end

    always_comb begin
        if ((op == OP_SLT) || (op == OP_SLTU))
            assert_cmp_is_bit_R8: assert (out_val[DATA_W-1:1] == '0);
    end
endmodule

// File: rtl/alu_exec.sv
`timescale 1ns/1ps
module alu_exec
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 5
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [3:0]        op_sel,
    input  logic              use_imm,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              ovf_trap
);
    localparam int LOW_W = DATA_W - IMM_W;

    alu_op_e           op;
    logic              valid_op;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_sel;
    logic [DATA_W-1:0] as_sum;
    logic              as_ovf;
    logic [DATA_W-1:0] lc_val;
    logic              is_sub;

    always_comb begin
        op       = alu_op_e'(op_sel);
        valid_op = (op_sel <= 4'(OP_LUI));
        b_sel    = use_imm ? imm_ext : opnd_b;
        is_sub   = (op == OP_SUB) || (op == OP_SUBU);
    end

    imm_extend #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
        .imm_in   (imm),
        .zero_ext (op_zero_ext(op)),
        .ext_out  (imm_ext)
    );

    addsub_unit #(.DATA_W(DATA_W)) u_as (
        .in_a    (opnd_a),
        .in_b    (b_sel),
        .do_sub  (is_sub),
        .sum_out (as_sum),
        .ovf     (as_ovf)
    );

    logic_cmp_unit #(.DATA_W(DATA_W)) u_lc (
        .in_a    (opnd_a),
        .in_b    (b_sel),
        .op      (op),
        .out_val (lc_val)
    );

    always_comb begin
        if (!valid_op)
            result = '0;
        else if (op == OP_LUI)
            result = {imm, {LOW_W{1'b0}}};
        else if (op <= OP_SUBU)
            result = as_sum;
        else
            result = lc_val;
        ovf_trap = valid_op && op_traps(op) && as_ovf;
        wr_en    = valid_op && !ovf_trap && (dest_idx != '0);
    end

    always_comb begin
        if (ovf_trap)
            assert_trap_blocks_write_R1: assert (!wr_en && op_traps(op));
        if ((op == OP_ADDU) || (op == OP_SUBU))
            assert_wrap_never_traps_R2: assert (!ovf_trap);
        if (dest_idx == '0)
            assert_zero_dest_no_write_R9: assert (!wr_en);
        if (op == OP_LUI)
            assert_lui_low_clear_R6: assert (result[LOW_W-1:0] == '0);
        if (!valid_op)
            assert_unused_op_idle_R10: assert (!wr_en && !ovf_trap && result == '0);
    end
endmodule

// File: tb/sim_alu_exec.sv
`timescale 1ns/1ps
module sim_alu_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b, res;
    logic [15:0] imm;
    logic [3:0]  op;
    logic        ui;
    logic [4:0]  dst;
    logic        we, tr;
    int checks = 0;
    int errors = 0;
    logic [31:0] vals [10];

    always #5 clk = ~clk;

    alu_exec u0 (
        .opnd_a(a), .opnd_b(b), .imm(imm), .op_sel(op), .use_imm(ui),
        .dest_idx(dst), .result(res), .wr_en(we), .ovf_trap(tr)
    );

    task automatic model(output logic [31:0] er, output logic ew, output logic et);
        logic [31:0] bo;
        longint s;
        et = 1'b0;
        er = 32'd0;
        if (ui) bo = (op >= 4 && op <= 7) ? {16'd0, imm} : {{16{imm[15]}}, imm};
        else    bo = b;
        case (op)
            0, 1: begin
                s  = longint'($signed(a)) + longint'($signed(bo));
                er = a + bo;
                et = (op == 0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            2, 3: begin
                s  = longint'($signed(a)) - longint'($signed(bo));
                er = a - bo;
                et = (op == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4: er = a & bo;
            5: er = a | bo;
            6: er = a ^ bo;
            7: er = ~(a | bo);
            8: er = ($signed(a) < $signed(bo)) ? 32'd1 : 32'd0;
            9: er = (a < bo) ? 32'd1 : 32'd0;
            10: er = {imm, 16'd0};
            default: er = 32'd0;
        endcase
        ew = (op <= 10) && !et && (dst != 5'd0);
    endtask

    function automatic string tag_of();
        if (dst == 5'd0) return "R9";
        if (op > 10) return "R10";
        if (op == 10) return "R6";
        if (ui && op == 9) return "R4";
        if (ui && op >= 4 && op <= 7) return "R5";
        if (ui) return "R3";
        if (op == 0 || op == 2) return "R1";
        if (op == 1 || op == 3) return "R2";
        if (op == 7) return "R7";
        if (op >= 8) return "R8";
        return "R11";
    endfunction

    task automatic check_now();
        logic [31:0] er;
        logic ew, et;
        model(er, ew, et);
        checks++;
        if (res !== er || we !== ew || tr !== et) begin
            errors++;
            $display("FAIL %s op=%0d ui=%0b a=%h b=%h imm=%h: got res=%h we=%b tr=%b, expected res=%h we=%b tr=%b",
                     tag_of(), op, ui, a, b, imm, res, we, tr, er, ew, et);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int step;
        step = 0;
        vals = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'h8000_0001, 32'h0000_7FFF, 32'h0000_8000,
                 32'hFFFF_8000, 32'h1234_ABCD};
        a = '0; b = '0; imm = '0; op = '0; ui = 1'b0; dst = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now();  // idle state: zero inputs, dest 0 (R9)
        for (int o = 0; o < 16; o++)
            for (int m = 0; m < 2; m++)
                for (int i = 0; i < 10; i++)
                    for (int j = 0; j < 10; j++) begin
                        @(posedge clk);
                        a   = vals[i];
                        b   = vals[j];
                        op  = 4'(o);
                        ui  = 1'(m);
                        imm = m ? vals[j][15:0] : ~vals[j][15:0];
                        dst = 5'(step % 7);
                        step++;
                        @(negedge clk);
                        check_now();
                    end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule